// File: doc/BRIEF.md
# Supply Reset and Watchdog Supervisor

This block turns already-digitized supply comparator results into a clean, active-low system reset. Whenever the main supply is reported below its reset threshold, the reset output falls combinationally, with no clock edge on the path. When the supply comes back, the block counts a fixed number of clock ticks before it lets reset go. A supply drop during that count abandons it, and the next rise starts a full count again.

A watchdog monitors a strobe input from the processor. Every change of level on that strobe, rising or falling, passes through a two-flop synchronizer and then clears the watchdog counter. If the counter reaches its limit, reset is pulled low and the block runs through the same release delay as a supply fault. The counter is held at zero while reset is asserted. An input that marks the strobe as unconnected keeps the watchdog cleared, so it never expires. A second comparator input, set slightly above the reset threshold, is passed out as an active-low early warning. Both tick counts are parameters. Every input is assumed synchronous to `clk` except the strobe and the power-present flag, which acts as the asynchronous clear.

Top module: `supply_supervisor`

## Requirements
- R1: `sup_rst_n` is 0 in the same cycle that `vdd_ok` is 0 or `pwr_present` is 0, with no clock edge needed.
- R2: With `vdd_ok` held at 1, `sup_rst_n` rises after exactly DELAY_TICKS rising clock edges that sample `vdd_ok` high, and not before.
- R3: If `vdd_ok` falls during a release count, that count is dropped, and the next rise of `vdd_ok` needs a full DELAY_TICKS edges again.
- R4: If no strobe edge is seen and `wdi_float` is 0, `sup_rst_n` falls exactly WDOG_TICKS edges after it was released.
- R5: A watchdog expiry holds `sup_rst_n` low for exactly DELAY_TICKS cycles. After that release, the watchdog counts again from zero.
- R6: A rising edge of `wdi` clears the watchdog. The clear takes effect on the third clock edge after the change: two synchronizer stages, then the edge compare. A change seen after k edges therefore prevents the expiry when k <= WDOG_TICKS-3.
- R7: A falling edge of `wdi` clears the watchdog with the same latency as in R6.
- R8: While `wdi_float` is 1, the watchdog never expires. After `wdi_float` returns to 0, expiry comes exactly WDOG_TICKS edges later.
- R9: `early_warn_n` equals `vdd_warn_ok` while `pwr_present` is 1, and it is 0 while `pwr_present` is 0.
- R10: While reset is asserted, the watchdog counter stays at zero. Even after a supply fault longer than the timeout, the first expiry after release comes exactly WDOG_TICKS edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock for both counters |
| pwr_present | input | 1 | Goes high once any supply is present; low clears everything asynchronously |
| vdd_ok | input | 1 | Main supply is above the reset threshold |
| vdd_warn_ok | input | 1 | Main supply is above the early-warning threshold |
| wdi | input | 1 | Watchdog strobe from the processor, asynchronous |
| wdi_float | input | 1 | Marks the strobe as unconnected, which disables expiry |
| sup_rst_n | output | 1 | Active-low system reset |
| early_warn_n | output | 1 | Active-low early power-fail warning |

## Verification
A release counter that is wrong or stale would move the rising edge of `sup_rst_n` by one or more cycles. The bench finds this by placing a supply drop at every offset within the delay window and then checking the release on the exact edge. A watchdog counter that is not cleared during reset, or that misses an edge of one polarity, would make reset fall at the wrong edge after release. Strobe changes placed at each offset around the timeout boundary show this within one timeout period. An early-warning fault shows up at once, because that path is combinational.

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
  parameter int unsigned DELAY_TICKS = 3277,
  parameter int unsigned WDOG_TICKS  = 26214
) (
  input  logic clk,
  input  logic pwr_present,
  input  logic vdd_ok,
  input  logic vdd_warn_ok,
  input  logic wdi,
  input  logic wdi_float,
  output logic sup_rst_n,
  output logic early_warn_n
);
  localparam int DW = $clog2(DELAY_TICKS + 1);
  localparam int WW = $clog2(WDOG_TICKS + 1);

  logic [DW-1:0] dly_cnt;
  logic [WW-1:0] wd_cnt;
  logic          released;
  logic [2:0]    wdi_sh;

  logic wdi_edge, wd_clear, wd_expire, dly_last;

  assign wdi_edge  = wdi_sh[2] ^ wdi_sh[1];
  assign wd_clear  = !released || !vdd_ok || wdi_edge || wdi_float;
  assign wd_expire = !wd_clear && (wd_cnt == WW'(WDOG_TICKS - 1));
  assign dly_last  = (dly_cnt == DW'(DELAY_TICKS - 1));

  always_ff @(posedge clk or negedge pwr_present) begin
    if (!pwr_present) begin
      wdi_sh   <= '0;
      wd_cnt   <= '0;
      dly_cnt  <= '0;
      released <= 1'b0;
    end else begin
      wdi_sh <= {wdi_sh[1:0], wdi};
      wd_cnt <= (wd_clear || wd_expire) ? '0 : wd_cnt + 1'b1;
      if (!vdd_ok) begin
        released <= 1'b0;
        dly_cnt  <= '0;
      end else if (released) begin
        if (wd_expire) released <= 1'b0;
      end else if (dly_last) begin
        released <= 1'b1;
        dly_cnt  <= '0;
      end else begin
        dly_cnt <= dly_cnt + 1'b1;
      end
    end
  end

  assign sup_rst_n    = released && vdd_ok;
  assign early_warn_n = pwr_present && vdd_warn_ok;
endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk #(
  parameter int unsigned DELAY_TICKS = 3277
) (
  input logic clk,
  input logic pwr_present,
  input logic vdd_ok,
  input logic vdd_warn_ok,
  input logic wdi_float,
  input logic sup_rst_n,
  input logic early_warn_n
);
  localparam int RW = $clog2(DELAY_TICKS + 2);
  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge pwr_present) begin
    if (!pwr_present) low_run <= '0;
    else if (!sup_rst_n && vdd_ok) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  a_r1_low_on_bad_supply: assert property (@(posedge clk) disable iff (!pwr_present)
    !vdd_ok |-> !sup_rst_n);

  a_r2_release_after_full_delay: assert property (@(posedge clk) disable iff (!pwr_present)
    $rose(sup_rst_n) |-> low_run == RW'(DELAY_TICKS));

  a_r5_low_run_bounded: assert property (@(posedge clk) disable iff (!pwr_present)
    (!sup_rst_n && vdd_ok) |-> low_run < RW'(DELAY_TICKS));

  a_r8_float_holds_release: assert property (@(posedge clk) disable iff (!pwr_present)
    (sup_rst_n && wdi_float) |=> (sup_rst_n || !vdd_ok));

  a_r9_warn_follows_input: assert property (@(posedge clk) disable iff (!pwr_present)
    early_warn_n == vdd_warn_ok);
endmodule

bind supply_supervisor supply_supervisor_chk #(.DELAY_TICKS(DELAY_TICKS)) u_chk (
  .clk(clk), .pwr_present(pwr_present), .vdd_ok(vdd_ok), .vdd_warn_ok(vdd_warn_ok),
  .wdi_float(wdi_float), .sup_rst_n(sup_rst_n), .early_warn_n(early_warn_n)
);

// File: tb/supply_supervisor_bench.sv
`timescale 1ns/1ps
module supply_supervisor_bench;
  localparam int D = 20;
  localparam int W = 40;

  logic clk = 1'b0;
  logic pwr_present = 1'b0, vdd_ok = 1'b0, vdd_warn_ok = 1'b0;
  logic wdi = 1'b0, wdi_float = 1'b0;
  logic sup_rst_n, early_warn_n;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.DELAY_TICKS(D), .WDOG_TICKS(W)) u_supply_supervisor (
    .clk(clk), .pwr_present(pwr_present), .vdd_ok(vdd_ok), .vdd_warn_ok(vdd_warn_ok),
    .wdi(wdi), .wdi_float(wdi_float), .sup_rst_n(sup_rst_n), .early_warn_n(early_warn_n));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk(sup_rst_n, 1'b0, "R1 no power");
    chk(early_warn_n, 1'b0, "R9 no power");
    pwr_present = 1'b1;
    step(5);
    chk(sup_rst_n, 1'b0, "R1 supply low");
    // R2 power-up release exactly D edges
    vdd_ok = 1'b1;
    step(D - 1); chk(sup_rst_n, 1'b0, "R2 early");
    step(1);     chk(sup_rst_n, 1'b1, "R2 on time");
    // R3 sweep of drop position during the count
    for (int k = 1; k < D; k++) begin
      vdd_ok = 1'b0; #1;
      chk(sup_rst_n, 1'b0, "R1 immediate drop");
      step(2); vdd_ok = 1'b1;
      step(k); vdd_ok = 1'b0;
      step(2); vdd_ok = 1'b1;
      step(D - 1); chk(sup_rst_n, 1'b0, "R3 restarted early");
      step(1);     chk(sup_rst_n, 1'b1, "R3 restarted on time");
    end
    // R4 timeout, R5 pulse width and restart
    step(W - 1); chk(sup_rst_n, 1'b1, "R4 before timeout");
    step(1);     chk(sup_rst_n, 1'b0, "R4 at timeout");
    step(D - 1); chk(sup_rst_n, 1'b0, "R5 pulse early");
    step(1);     chk(sup_rst_n, 1'b1, "R5 pulse end");
    step(W - 1); chk(sup_rst_n, 1'b1, "R5 restart before");
    step(1);     chk(sup_rst_n, 1'b0, "R5 restart timeout");
    step(D);     chk(sup_rst_n, 1'b1, "R5 release again");
    // R10 long fault longer than the timeout
    vdd_ok = 1'b0; step(2 * W); vdd_ok = 1'b1;
    step(D);     chk(sup_rst_n, 1'b1, "R10 release");
    step(W - 1); chk(sup_rst_n, 1'b1, "R10 before timeout");
    step(1);     chk(sup_rst_n, 1'b0, "R10 at timeout");
    step(D);     chk(sup_rst_n, 1'b1, "R10 release after timeout");
    // R6/R7 kick sweep around the boundary, both polarities
    for (int k = W - 8; k <= W - 1; k++) begin
      string tg;
      step(k);
      wdi = ~wdi;
      tg = wdi ? "R6" : "R7";
      if (k <= W - 3) begin
        step(W - k);  chk(sup_rst_n, 1'b1, {tg, " kick in time"});
        step(k + 2);  chk(sup_rst_n, 1'b1, {tg, " before late timeout"});
        step(1);      chk(sup_rst_n, 1'b0, {tg, " timeout after kick"});
      end else begin
        step(W - k);  chk(sup_rst_n, 1'b0, {tg, " kick too late"});
      end
      step(D - 1); chk(sup_rst_n, 1'b0, "R5 pulse early");
      step(1);     chk(sup_rst_n, 1'b1, "R5 pulse end");
    end
    // R8 floating strobe
    wdi_float = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(W); chk(sup_rst_n, 1'b1, "R8 float no timeout");
    end
    wdi_float = 1'b0;
    step(W - 1); chk(sup_rst_n, 1'b1, "R8 after float before");
    step(1);     chk(sup_rst_n, 1'b0, "R8 after float timeout");
    step(D);     chk(sup_rst_n, 1'b1, "R8 release");
    // R9 early warning, all input combinations
    for (int p = 1; p >= 0; p--) begin
      for (int w = 0; w < 2; w++) begin
        pwr_present = p[0]; vdd_warn_ok = w[0]; #1;
        chk(early_warn_n, p[0] & w[0], "R9 warn");
        if (!p[0]) chk(sup_rst_n, 1'b0, "R1 power removed");
        step(1);
      end
    end
    finish_run();
  end
endmodule